// File: doc/BRIEF.md
# Toggle-Bit Status Poller for Parallel NOR Flash

After host logic has sent a program or erase command sequence to a parallel NOR flash, this block decides whether the operation succeeded. It reads the device's status byte again and again over a simple request/acknowledge bus. It compares the toggle bit (bit 6) of each read with the previous read, and it watches the timeout flag (bit 5).

When two reads in a row agree on bit 6, the block makes one more read to fetch valid data, presents that byte and reports pass. If the timeout flag shows while bit 6 is still moving, the block does not yet trust the flag: it takes a fresh pair of reads and declares failure only if bit 6 still differs. On any failure it writes the reset byte F0h to the polled address, so that the device goes back to array read, and then reports fail. A parameter caps the number of polling reads, so a device that never settles also ends in the failure path.

The block is idle until a one-cycle start pulse arrives with the address to poll. It finishes every operation with a one-cycle done pulse that carries a pass/fail bit.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After reset the block is idle: bus_req_o, done_o, pass_o are low and result_o is 00h.
- R2: A start_i pulse while idle captures addr_i and begins status reads at that address; every transfer of the operation uses it; start_i while busy is ignored.
- R3: A request holds bus_req_o, bus_we_o and bus_addr_o unchanged until the cycle bus_ack_i is seen; each acknowledge completes exactly one transfer.
- R4: When two consecutive status reads of a pair agree on bit 6, the block performs exactly one further read, presents its byte on result_o and ends with pass.
- R5: When consecutive status reads differ in bit 6 and the newer has bit 5 at 0, polling continues with another status read; bit 5 has no effect once bit 6 agrees.
- R6: When consecutive reads differ in bit 6 and the newer has bit 5 at 1, the block starts a fresh pair of status reads; agreement in that pair leads to the pass path of R4, disagreement leads to the fail path.
- R7: The fail path is a single bus write of F0h (bus_we_o high) to the polled address, followed by done with pass_o low.
- R8: Outside a recheck, after MAX_POLLS status reads without settling, the block takes the fail path with no further status read.
- R9: If the read that reaches MAX_POLLS also shows bit 6 toggling with bit 5 at 1, the recheck of R6 takes priority over the limit, and recheck reads are exempt from the limit.
- R10: done_o is high for exactly one cycle per operation, one cycle after the final acknowledge, with pass_o valid in that cycle; result_o holds the last passed data through later failures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin polling |
| addr_i | input | AW | Address to poll, captured at start |
| bus_req_o | output | 1 | Bus transfer request |
| bus_we_o | output | 1 | Transfer is a write (reset command) |
| bus_addr_o | output | AW | Transfer address |
| bus_wdata_o | output | 8 | Write data (F0h during a write) |
| bus_ack_i | input | 1 | Transfer acknowledge, one cycle |
| bus_rdata_i | input | 8 | Read data, valid with bus_ack_i |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Outcome, valid with done_o |
| result_o | output | 8 | Settled data byte from the last pass |

## Verification
The poll limit and the timeout-flag recheck can both trigger on the same status read: the read that brings the count to MAX_POLLS may also show bit 6 moving with bit 5 set. The bench provokes this with a response script that toggles through MAX_POLLS-1 reads and then returns a toggled byte with bit 5 set on the limit read, followed by a settled pair. The design must recheck and pass with MAX_POLLS+3 reads and no reset write; the bench's behavioural model predicts the read count, the write count, the outcome and the data byte.

// File: rtl/toggle_poll_pkg.sv
package toggle_poll_pkg;

  localparam int          TOG_BIT   = 6;
  localparam int          TMO_BIT   = 5;
  localparam logic [7:0]  RESET_CMD = 8'hF0;

  typedef enum logic [2:0] {
    S_IDLE,
    S_STAT,
    S_EVAL,
    S_FINAL,
    S_ABORT,
    S_DONE
  } state_t;

  typedef enum logic [1:0] {
    V_AGAIN,
    V_SETTLED,
    V_RECHECK,
    V_FAILED
  } verdict_t;

  // two samples of the toggle bit disagree: device still busy
  function automatic logic still_busy(input logic older, input logic newer);
    return older ^ newer;
  endfunction

  // count has reached the configured cap
  function automatic logic cap_reached(input int unsigned count, input int unsigned cap);
    return count >= cap;
  endfunction

endpackage

// File: rtl/toggle_poll_eval.sv
module toggle_poll_eval
  import toggle_poll_pkg::*;
(
  input  logic     have_prev_i,
  input  logic     recheck_i,
  input  logic     prev_tog_i,
  input  logic     cur_tog_i,
  input  logic     cur_tmo_i,
  input  logic     limit_i,
  output verdict_t verdict_o
);

  logic busy;
  assign busy = still_busy(prev_tog_i, cur_tog_i);

  always_comb begin
    if (!have_prev_i) begin
      verdict_o = (limit_i && !recheck_i) ? V_FAILED : V_AGAIN;
    end else if (!busy) begin
      verdict_o = V_SETTLED;
    end else if (recheck_i) begin
      verdict_o = V_FAILED;
    end else if (cur_tmo_i) begin
      verdict_o = V_RECHECK;
    end else if (limit_i) begin
      verdict_o = V_FAILED;
    end else begin
      verdict_o = V_AGAIN;
    end
  end

endmodule

// File: rtl/toggle_poll_cnt.sv
module toggle_poll_cnt
  import toggle_poll_pkg::*;
#(
  parameter int unsigned MAX_POLLS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic limit_o
);

  localparam int unsigned CW = $clog2(MAX_POLLS + 1);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clr_i) begin
      count_q <= '0;
    end else if (inc_i && !limit_o) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign limit_o = cap_reached(int'(count_q), MAX_POLLS);

endmodule

// File: rtl/toggle_poll_result.sv
module toggle_poll_result (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_pass_i,
  input  logic       load_fail_i,
  input  logic [7:0] data_i,
  output logic       pass_o,
  output logic [7:0] data_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_o <= 1'b0;
      data_o <= 8'h00;
    end else if (load_pass_i) begin
      pass_o <= 1'b1;
      data_o <= data_i;
    end else if (load_fail_i) begin
      pass_o <= 1'b0;
    end
  end

endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl
  import toggle_poll_pkg::*;
#(
  parameter int unsigned AW        = 19,
  parameter int unsigned MAX_POLLS = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [7:0]    bus_wdata_o,
  input  logic          bus_ack_i,
  input  logic [7:0]    bus_rdata_i,
  output logic          done_o,
  output logic          pass_o,
  output logic [7:0]    result_o
);

  state_t        state_q;
  logic [AW-1:0] addr_q;
  logic          have_prev_q;
  logic          recheck_q;
  logic          prev_tog_q;
  logic          cur_tog_q;
  logic          cur_tmo_q;
  logic          limit;
  verdict_t      verdict;

  // named internal events, observed by the checker
  logic ev_start;
  logic ev_status_ack;
  logic ev_final_ack;
  logic ev_reset_ack;

  assign ev_start      = (state_q == S_IDLE)  && start_i;
  assign ev_status_ack = (state_q == S_STAT)  && bus_ack_i;
  assign ev_final_ack  = (state_q == S_FINAL) && bus_ack_i;
  assign ev_reset_ack  = (state_q == S_ABORT) && bus_ack_i;

  toggle_poll_cnt #(.MAX_POLLS(MAX_POLLS)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (ev_start),
    .inc_i   (ev_status_ack),
    .limit_o (limit)
  );

  toggle_poll_eval u_eval (
    .have_prev_i (have_prev_q),
    .recheck_i   (recheck_q),
    .prev_tog_i  (prev_tog_q),
    .cur_tog_i   (cur_tog_q),
    .cur_tmo_i   (cur_tmo_q),
    .limit_i     (limit),
    .verdict_o   (verdict)
  );

  toggle_poll_result u_res (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_pass_i (ev_final_ack),
    .load_fail_i (ev_reset_ack),
    .data_i      (bus_rdata_i),
    .pass_o      (pass_o),
    .data_o      (result_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      addr_q      <= '0;
      have_prev_q <= 1'b0;
      recheck_q   <= 1'b0;
      prev_tog_q  <= 1'b0;
      cur_tog_q   <= 1'b0;
      cur_tmo_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (start_i) begin
            addr_q      <= addr_i;
            have_prev_q <= 1'b0;
            recheck_q   <= 1'b0;
            state_q     <= S_STAT;
          end
        end
        S_STAT: begin
          if (bus_ack_i) begin
            cur_tog_q <= bus_rdata_i[TOG_BIT];
            cur_tmo_q <= bus_rdata_i[TMO_BIT];
            state_q   <= S_EVAL;
          end
        end
        S_EVAL: begin
          unique case (verdict)
            V_AGAIN: begin
              prev_tog_q  <= cur_tog_q;
              have_prev_q <= 1'b1;
              state_q     <= S_STAT;
            end
            V_SETTLED: state_q <= S_FINAL;
            V_RECHECK: begin
              recheck_q   <= 1'b1;
              have_prev_q <= 1'b0;
              state_q     <= S_STAT;
            end
            default:   state_q <= S_ABORT;
          endcase
        end
        S_FINAL: if (bus_ack_i) state_q <= S_DONE;
        S_ABORT: if (bus_ack_i) state_q <= S_DONE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  assign bus_req_o   = (state_q == S_STAT) || (state_q == S_FINAL) || (state_q == S_ABORT);
  assign bus_we_o    = (state_q == S_ABORT);
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = bus_we_o ? RESET_CMD : 8'h00;
  assign done_o      = (state_q == S_DONE);

endmodule

// File: rtl/toggle_poll_chk.sv
module toggle_poll_chk
  import toggle_poll_pkg::*;
#(
  parameter int unsigned AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [7:0]    bus_wdata_o,
  input logic          bus_ack_i,
  input logic          done_o,
  input logic          pass_o,
  input logic          ev_final_ack,
  input logic          ev_reset_ack
);

  // R10: done lasts one cycle
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10: done follows a final-read or reset-write acknowledge
  assert_done_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(ev_final_ack || ev_reset_ack));

  // R3: request and its attributes hold until acknowledged
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)));

  // R7: any write carries the reset byte
  assert_reset_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && bus_we_o) |-> (bus_wdata_o == RESET_CMD));

  // R7: acknowledged reset write ends with fail
  assert_fail_after_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reset_ack |=> (done_o && !pass_o));

  // R4: acknowledged final read ends with pass
  assert_pass_after_final_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_final_ack |=> (done_o && pass_o));

endmodule

bind toggle_poll_ctrl toggle_poll_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_req_o    (bus_req_o),
  .bus_we_o     (bus_we_o),
  .bus_addr_o   (bus_addr_o),
  .bus_wdata_o  (bus_wdata_o),
  .bus_ack_i    (bus_ack_i),
  .done_o       (done_o),
  .pass_o       (pass_o),
  .ev_final_ack (ev_final_ack),
  .ev_reset_ack (ev_reset_ack)
);

// File: tb/toggle_poll_ctrl_bench.sv
module toggle_poll_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 12;
  localparam int MAXP       = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          bus_req_o, bus_we_o;
  logic [AW-1:0] bus_addr_o;
  logic [7:0]    bus_wdata_o;
  logic          bus_ack_i = 1'b0;
  logic [7:0]    bus_rdata_i = 8'h00;
  logic          done_o, pass_o;
  logic [7:0]    result_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  toggle_poll_ctrl #(.AW(AW), .MAX_POLLS(MAXP)) u_toggle_poll_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i),
    .done_o(done_o), .pass_o(pass_o), .result_o(result_o)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // responder state
  logic [7:0]    rsp_q[$];
  int            lat = 0;
  int            wait_cnt = 0;
  int            n_rd = 0;
  int            n_wr = 0;
  logic [AW-1:0] exp_addr = '0;
  int            dones = 0;
  bit            got_pass;
  logic [7:0]    got_data;

  always @(negedge clk) begin
    if (bus_ack_i) begin
      bus_ack_i = 1'b0;
      wait_cnt  = 0;
    end else if (bus_req_o) begin
      if (wait_cnt >= lat) begin
        wait_cnt  = 0;
        bus_ack_i = 1'b1;
        chk(bus_addr_o == exp_addr, "R2 addr", int'(bus_addr_o), int'(exp_addr));
        if (bus_we_o) begin
          n_wr++;
          chk(bus_wdata_o == 8'hF0, "R7 reset byte", int'(bus_wdata_o), 8'hF0);
        end else begin
          n_rd++;
          bus_rdata_i = (rsp_q.size() > 0) ? rsp_q.pop_front() : 8'h00;
        end
      end else begin
        wait_cnt++;
      end
    end
    if (done_o) begin
      dones++;
      got_pass = pass_o;
      got_data = result_o;
    end
  end

  // behavioural expectation: walk the scripted replies
  task automatic predict(input logic [7:0] q[$], output int rd, output int wr,
                         output bit ps, output logic [7:0] dat);
    int  k = 0;
    bit  fresh = 1'b1;
    bit  in_recheck = 1'b0;
    logic last6 = 1'b0;
    rd = 0; wr = 0; ps = 1'b0; dat = 8'h00;
    while (1) begin
      logic [7:0] b;
      b = (k < q.size()) ? q[k] : 8'h00;
      k++; rd++;
      if (fresh) begin
        last6 = b[6];
        fresh = 1'b0;
        if (!in_recheck && rd >= MAXP) begin wr = 1; break; end
      end else if (last6 == b[6]) begin
        dat = (k < q.size()) ? q[k] : 8'h00;
        rd++; ps = 1'b1; break;
      end else if (in_recheck) begin
        wr = 1; break;
      end else if (b[5]) begin
        in_recheck = 1'b1; fresh = 1'b1;
      end else begin
        last6 = b[6];
        if (rd >= MAXP) begin wr = 1; break; end
      end
    end
  endtask

  task automatic run_case(input string tag, input logic [7:0] q[$],
                          input logic [AW-1:0] a, input int l, input bit restart);
    int e_rd, e_wr; bit e_ps; logic [7:0] e_dat;
    logic [7:0] keep;
    int guard = 0;
    keep = result_o;
    predict(q, e_rd, e_wr, e_ps, e_dat);
    rsp_q = q; lat = l; n_rd = 0; n_wr = 0; dones = 0; exp_addr = a;
    @(negedge clk); start_i = 1'b1; addr_i = a;
    @(negedge clk); start_i = 1'b0; addr_i = ~a;
    if (restart) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
    end
    while (dones == 0 && guard < 5000) begin @(posedge clk); guard++; end
    chk(dones == 1, {tag, " R10 done seen"}, dones, 1);
    chk(n_rd == e_rd, {tag, " reads"}, n_rd, e_rd);
    chk(n_wr == e_wr, {tag, " R7 writes"}, n_wr, e_wr);
    chk(got_pass == e_ps, {tag, " R10 pass"}, int'(got_pass), int'(e_ps));
    chk(got_data == (e_ps ? e_dat : keep), {tag, " R10 result"}, int'(got_data),
        int'(e_ps ? e_dat : keep));
    repeat (4) @(posedge clk);
    chk(dones == 1, {tag, " R10 single pulse"}, dones, 1);
    chk(!bus_req_o, {tag, " idle after done"}, int'(bus_req_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!bus_req_o && !done_o && !pass_o, "R1 idle", int'(bus_req_o), 0);
    chk(result_o == 8'h00, "R1 result", int'(result_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!bus_req_o, "R1 no request without start", int'(bus_req_o), 0);

    run_case("R4 settled at once", '{8'h40, 8'h40, 8'hA5}, 12'h123, 0, 0);
    run_case("R5 toggle then settle", '{8'h40, 8'h00, 8'h40, 8'h00, 8'h00, 8'h3C}, 12'h0F0, 2, 0);
    run_case("R5 flag when settled", '{8'h60, 8'h60, 8'h81}, 12'h7FF, 1, 0);
    run_case("R6 recheck passes", '{8'h40, 8'h20, 8'h11, 8'h11, 8'h77}, 12'h456, 0, 0);
    run_case("R6 R7 recheck fails", '{8'h40, 8'h20, 8'h64, 8'h24}, 12'h321, 1, 0);
    run_case("R8 limit", '{8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00},
             12'h0AA, 0, 0);
    run_case("R9 limit meets flag", '{8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h20,
             8'h55, 8'h55, 8'h99}, 12'h555, 0, 0);
    run_case("R2 start while busy", '{8'h00, 8'h40, 8'h00, 8'h40, 8'h40, 8'hE1}, 12'h2C3, 3, 1);
    run_case("R3 slow bus", '{8'h40, 8'h00, 8'h00, 8'h5A}, 12'h001, 4, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule